// File: doc/BRIEF.md
# Display RAM Address Pointer Unit

This block tracks where the next display byte goes in a bit-mapped display memory of 102 columns by 65 pixel rows. The rows form nine banks: eight are eight rows tall and the last is one row tall. A column pointer and a bank pointer are loaded by separate set commands. Each accepted data byte then produces a write strobe, a physical column, a bank index, a row mask and the data bits ordered for the bank. In the same clock edge the pointer moves to the next location.

A mode input picks the axis that advances. In horizontal mode the column steps forward and carries into the bank. In vertical mode the bank steps forward and carries into the column. Both pointers wrap back to zero after the last location. A mirror input reflects the column so that logical column 0 drives the rightmost physical column. A bit-order input selects which byte bit lands in the top row of a bank. The storage array and the serial front end sit outside this block.

Top module: `disp_ptr_unit`

## Requirements
- R1: While rst_ni is low, and after it is released, the column pointer and the bank pointer are both 0. With no byte present, wr_en_o, mask_o and data_o are 0.
- R2: When vert_i=0, each byte advances the column by one. From column 101 the column goes to 0 and the bank advances by one.
- R3: When vert_i=1, each byte advances the bank by one. From bank 8 the bank goes to 0 and the column advances by one.
- R4: A byte written at column 101 and bank 8 returns both pointers to 0 in either mode.
- R5: A set-column value of 0 to 101 or a set-bank value of 0 to 8 is loaded at the next edge. A larger value is ignored and leaves that pointer unchanged.
- R6: col_o equals the column pointer when mirror_i=0, and equals 101 minus the pointer when mirror_i=1. mirror_i acts in the same cycle and does not change the pointer.
- R7: While a byte is present in banks 0 to 7, data_o[k]=byte_i[k] when msb_bot_i=0, and data_o[k]=byte_i[7-k] when msb_bot_i=1. Bit k of data_o and mask_o is row k of the bank, with row 0 at the top.
- R8: mask_o is 8'hFF for a byte in banks 0 to 7 and 8'h01 for bank 8. In bank 8, data_o[0] takes the bit that R7 places in row 0, and data_o[7:1] is 0.
- R9: In a cycle with byte_vld_i=0, wr_en_o, mask_o and data_o are 0. Without a set command the pointers hold.
- R10: A byte in the cycle after another byte is written at the advanced location, with no idle cycle. A legal set command in the same cycle as a byte overrides the advance on its own axis only. The other axis takes its normal post-write value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setx_vld_i | input | 1 | Set-column command strobe |
| setx_val_i | input | 7 | Column value for the set command |
| sety_vld_i | input | 1 | Set-bank command strobe |
| sety_val_i | input | 4 | Bank value for the set command |
| vert_i | input | 1 | 1: vertical advance, 0: horizontal advance |
| mirror_i | input | 1 | 1: mirror the column onto the physical columns |
| msb_bot_i | input | 1 | 1: byte MSB goes to the top row |
| byte_vld_i | input | 1 | Data byte present this cycle |
| byte_i | input | 8 | Data byte |
| wr_en_o | output | 1 | Write strobe to the display memory |
| col_o | output | 7 | Physical column index |
| bank_o | output | 4 | Bank index |
| mask_o | output | 8 | Row write mask within the bank |
| data_o | output | 8 | Row-ordered data bits |

## Verification
A corrupted pointer shows on col_o and bank_o in the next cycle. It shows there whether or not a byte is present, so a wrong carry or wrap is caught on the very edge it happens. A bad bit order or mask shows on the same cycle the byte is presented. A wrong bank pointer also shows as a wrong mask width when it lands on or leaves bank 8. Because col_o depends on mirror_i, the bench toggles the mirror while the pointer runs. This keeps a fault in the mirror from hiding behind a correct count.

// File: rtl/disp_ptr_pkg.sv
package disp_ptr_pkg;
  localparam int unsigned DP_COLS  = 102;
  localparam int unsigned DP_BANKS = 9;
  localparam int unsigned DP_ROWS  = 8;
endpackage

// File: rtl/disp_ptr_axis.sv
// One wrapping pointer axis with guarded load.
module disp_ptr_axis #(
  parameter int unsigned MAX = 101,
  parameter int unsigned W   = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] val_o,
  output logic         last_o
);
  localparam logic [W-1:0] MAXV = W'(MAX);

  logic [W-1:0] q, nxt;

  assign val_o  = q;
  assign last_o = (q == MAXV);

  always_comb begin
    nxt = q;
    if (inc_i) nxt = last_o ? '0 : q + 1'b1;
    // out-of-range load values are dropped
    if (ld_i && (ld_val_i <= MAXV)) nxt = ld_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end
endmodule

// File: rtl/disp_col_map.sv
module disp_col_map #(
  parameter int unsigned COLS = 102,
  parameter int unsigned W    = 7
) (
  input  logic [W-1:0] x_i,
  input  logic         mirror_i,
  output logic [W-1:0] col_o
);
  localparam logic [W-1:0] XMAX = W'(COLS - 1);

  assign col_o = mirror_i ? (XMAX - x_i) : x_i;
endmodule

// File: rtl/disp_byte_fmt.sv
// Bit ordering and row mask; last bank is one row tall.
module disp_byte_fmt #(
  parameter int unsigned ROWS  = 8,
  parameter int unsigned BANKS = 9,
  parameter int unsigned YW    = 4
) (
  input  logic            vld_i,
  input  logic            msb_bot_i,
  input  logic [YW-1:0]   bank_i,
  input  logic [ROWS-1:0] byte_i,
  output logic [ROWS-1:0] mask_o,
  output logic [ROWS-1:0] data_o
);
  localparam logic [YW-1:0]   LAST_BANK = YW'(BANKS - 1);
  localparam logic [ROWS-1:0] ONE_ROW   = ROWS'(1);

  logic [ROWS-1:0] ordered;
  logic [ROWS-1:0] row_mask;

  for (genvar k = 0; k < ROWS; k++) begin : g_ord
    assign ordered[k] = msb_bot_i ? byte_i[ROWS-1-k] : byte_i[k];
  end

  assign row_mask = (bank_i == LAST_BANK) ? ONE_ROW : '1;
  assign mask_o   = vld_i ? row_mask : '0;
  assign data_o   = ordered & mask_o;
endmodule

// File: rtl/disp_ptr_unit.sv
module disp_ptr_unit #(
  parameter int unsigned COLS  = disp_ptr_pkg::DP_COLS,
  parameter int unsigned BANKS = disp_ptr_pkg::DP_BANKS,
  parameter int unsigned ROWS  = disp_ptr_pkg::DP_ROWS,
  localparam int unsigned XW   = $clog2(COLS),
  localparam int unsigned YW   = $clog2(BANKS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            setx_vld_i,
  input  logic [XW-1:0]   setx_val_i,
  input  logic            sety_vld_i,
  input  logic [YW-1:0]   sety_val_i,
  input  logic            vert_i,
  input  logic            mirror_i,
  input  logic            msb_bot_i,
  input  logic            byte_vld_i,
  input  logic [ROWS-1:0] byte_i,
  output logic            wr_en_o,
  output logic [XW-1:0]   col_o,
  output logic [YW-1:0]   bank_o,
  output logic [ROWS-1:0] mask_o,
  output logic [ROWS-1:0] data_o
);
  logic [XW-1:0] x_val;
  logic [YW-1:0] y_val;
  logic          x_last, y_last;
  logic          x_inc, y_inc;

  // primary axis always steps; the other steps on carry
  assign x_inc = byte_vld_i & (~vert_i | y_last);
  assign y_inc = byte_vld_i & ( vert_i | x_last);

  disp_ptr_axis #(.MAX(COLS - 1), .W(XW)) u_x (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (x_inc),
    .ld_i     (setx_vld_i),
    .ld_val_i (setx_val_i),
    .val_o    (x_val),
    .last_o   (x_last)
  );

  disp_ptr_axis #(.MAX(BANKS - 1), .W(YW)) u_y (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (y_inc),
    .ld_i     (sety_vld_i),
    .ld_val_i (sety_val_i),
    .val_o    (y_val),
    .last_o   (y_last)
  );

  disp_col_map #(.COLS(COLS), .W(XW)) u_map (
    .x_i      (x_val),
    .mirror_i (mirror_i),
    .col_o    (col_o)
  );

  disp_byte_fmt #(.ROWS(ROWS), .BANKS(BANKS), .YW(YW)) u_fmt (
    .vld_i     (byte_vld_i),
    .msb_bot_i (msb_bot_i),
    .bank_i    (y_val),
    .byte_i    (byte_i),
    .mask_o    (mask_o),
    .data_o    (data_o)
  );

  assign wr_en_o = byte_vld_i;
  assign bank_o  = y_val;
endmodule

// File: rtl/disp_ptr_chk.sv
module disp_ptr_chk #(
  parameter int unsigned COLS  = 102,
  parameter int unsigned BANKS = 9,
  parameter int unsigned ROWS  = 8,
  parameter int unsigned XW    = 7,
  parameter int unsigned YW    = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            setx_vld_i,
  input logic [XW-1:0]   setx_val_i,
  input logic            sety_vld_i,
  input logic            vert_i,
  input logic            byte_vld_i,
  input logic            wr_en_o,
  input logic [XW-1:0]   col_o,
  input logic [YW-1:0]   bank_o,
  input logic [ROWS-1:0] mask_o,
  input logic [XW-1:0]   x_val,
  input logic [YW-1:0]   y_val
);
  localparam logic [XW-1:0] XMAX = XW'(COLS - 1);
  localparam logic [YW-1:0] YMAX = YW'(BANKS - 1);

  // R1
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_o <= XMAX) && (bank_o <= YMAX));

  // R2
  horiz_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i && !vert_i && !setx_vld_i && !sety_vld_i && (x_val != XMAX)
    |=> (x_val == XW'($past(x_val) + 1'b1)) && (y_val == $past(y_val)));

  // R3
  vert_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i && vert_i && !setx_vld_i && !sety_vld_i && (y_val != YMAX)
    |=> (y_val == YW'($past(y_val) + 1'b1)) && (x_val == $past(x_val)));

  // R4
  full_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i && !setx_vld_i && !sety_vld_i && (x_val == XMAX) && (y_val == YMAX)
    |=> (x_val == '0) && (y_val == '0));

  // R5
  bad_setx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setx_vld_i && (setx_val_i > XMAX) && !byte_vld_i |=> $stable(x_val));

  // R8
  last_bank_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && (bank_o == YMAX) |-> $countones(mask_o) == 1);

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_i && !setx_vld_i && !sety_vld_i |=> $stable(x_val) && $stable(y_val));
endmodule

bind disp_ptr_unit disp_ptr_chk #(
  .COLS(COLS), .BANKS(BANKS), .ROWS(ROWS), .XW(XW), .YW(YW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .setx_vld_i (setx_vld_i),
  .setx_val_i (setx_val_i),
  .sety_vld_i (sety_vld_i),
  .vert_i     (vert_i),
  .byte_vld_i (byte_vld_i),
  .wr_en_o    (wr_en_o),
  .col_o      (col_o),
  .bank_o     (bank_o),
  .mask_o     (mask_o),
  .x_val      (x_val),
  .y_val      (y_val)
);

// File: tb/disp_ptr_unit_test.sv
module disp_ptr_unit_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       setx_vld_i = 1'b0;
  logic [6:0] setx_val_i = '0;
  logic       sety_vld_i = 1'b0;
  logic [3:0] sety_val_i = '0;
  logic       vert_i = 1'b0;
  logic       mirror_i = 1'b0;
  logic       msb_bot_i = 1'b0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic       wr_en_o;
  logic [6:0] col_o;
  logic [3:0] bank_o;
  logic [7:0] mask_o;
  logic [7:0] data_o;

  int n_cmp = 0;
  int n_bad = 0;
  int mx = 0;
  int my = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  disp_ptr_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .setx_vld_i(setx_vld_i), .setx_val_i(setx_val_i),
    .sety_vld_i(sety_vld_i), .sety_val_i(sety_val_i),
    .vert_i(vert_i), .mirror_i(mirror_i), .msb_bot_i(msb_bot_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .wr_en_o(wr_en_o), .col_o(col_o), .bank_o(bank_o),
    .mask_o(mask_o), .data_o(data_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (x=%0d y=%0d)", tag, what, act, exp, mx, my);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // one cycle: drive, compare mid-cycle, advance reference
  task automatic step(bit sxv, int sx, bit syv, int sy, bit v, bit mir, bit dob,
                      bit bv, int b, string tag);
    int ecol, emask, edata, nx, ny;
    @(posedge clk_i);
    #1;
    setx_vld_i = sxv; setx_val_i = 7'(sx);
    sety_vld_i = syv; sety_val_i = 4'(sy);
    vert_i = v; mirror_i = mir; msb_bot_i = dob;
    byte_vld_i = bv; byte_i = 8'(b);
    @(negedge clk_i);
    ecol = mir ? 101 - mx : mx;
    emask = 0; edata = 0;
    if (bv) begin
      if (my == 8) begin
        emask = 1;
        edata = dob ? ((b >> 7) & 1) : (b & 1);
      end else begin
        emask = 255;
        edata = 0;
        for (int k = 0; k < 8; k++)
          if (((dob ? (b >> (7 - k)) : (b >> k)) & 1) != 0) edata |= (1 << k);
      end
    end
    chk(tag, "col", int'(col_o), ecol);
    chk(tag, "bank", int'(bank_o), my);
    chk(bv ? "R10" : "R9", "wr_en", int'(wr_en_o), int'(bv));
    chk(bv ? "R8" : "R9", "mask", int'(mask_o), emask);
    chk(bv ? "R7" : "R9", "data", int'(data_o), edata);
    nx = mx; ny = my;
    if (bv) begin
      if (!v) begin
        if (mx == 101) begin nx = 0; ny = (my == 8) ? 0 : my + 1; end
        else nx = mx + 1;
      end else begin
        if (my == 8) begin ny = 0; nx = (mx == 101) ? 0 : mx + 1; end
        else ny = my + 1;
      end
    end
    if (sxv && sx <= 101) nx = sx;
    if (syv && sy <= 8) ny = sy;
    mx = nx; my = ny;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "col", int'(col_o), 0);
    chk("R1", "bank", int'(bank_o), 0);
    chk("R1", "wr_en", int'(wr_en_o), 0);
    chk("R1", "mask", int'(mask_o), 0);
    rst_ni = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");

    // R2 horizontal walk across the column wrap
    for (int i = 0; i < 110; i++) step(0, 0, 0, 0, 0, 0, 0, 1, i * 7, "R2");
    // R9 idle holds pointer
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, i[0], i[1], 0, 0, 8'hA5, "R9");
    // R6 mirroring, toggled mid-run
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 0, i[1], 0, 1, 8'h3C, "R6");

    // R5 legal and illegal loads
    step(1, 50, 1, 3, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
    step(1, 120, 0, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 1, 12, 0, 0, 0, 0, 0, "R5");
    step(1, 102, 1, 9, 0, 1, 0, 0, 0, "R5");
    step(1, 101, 1, 8, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");

    // R4 final location, horizontal then vertical
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h81, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    step(1, 101, 1, 8, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 1, 0, 1, 1, 8'h80, "R4");
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, "R4");

    // R3 vertical walk across bank and column carries
    step(1, 100, 1, 0, 1, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 30; i++) step(0, 0, 0, 0, 1, i[2], i[0], 1, i * 13 + 5, "R3");

    // R7 R8 bit order in full and short banks
    step(1, 10, 1, 3, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 1, 1, 8'b1100_1010, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'b1100_1010, "R7");
    step(0, 0, 1, 8, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 1, 1, 8'h80, "R8");
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'hFE, "R8");
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h01, "R8");

    // R10 set in the same cycle as a byte, both modes
    step(1, 40, 0, 0, 0, 0, 0, 1, 8'h11, "R10");
    step(0, 0, 1, 5, 0, 0, 0, 1, 8'h22, "R10");
    step(1, 101, 0, 0, 0, 0, 0, 1, 8'h33, "R10");
    step(0, 0, 1, 2, 1, 0, 0, 1, 8'h44, "R10");
    step(1, 7, 1, 8, 1, 0, 0, 1, 8'h55, "R10");
    step(1, 110, 0, 0, 1, 0, 0, 1, 8'h66, "R10");

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step(r < 6, int'($urandom_range(0, 127)), (r > 93), int'($urandom_range(0, 15)),
           i[9], $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
           $urandom_range(0, 9) < 8, int'($urandom_range(0, 255)), "R2 R3 R6 R10");
    end

    finish_run();
  end
endmodule